// File: doc/BRIEF.md
# Privileged Special-Register Access Gate

This block stands between the instructions that move values to and from special-purpose registers and the storage that holds those registers. Every access is first screened for privilege: it may proceed only when the supervisor bit or the user-read-permission bit is set. It is then classified by address. Reads and writes use separate allow-lists. A rejected access has no effect on state and raises a one-cycle warning.

A few write targets do more than store a value. A write to the status register stores the value but always leaves its fixed-one bit set. A write to the next-PC address stores nothing. Instead it emits a redirect strobe carrying the written value, and that strobe also tells the core to drop any pending delay-slot state. A write to the tick-timer mode address is discarded, and it raises the warning only when the data is nonzero.

Read data appears combinationally in the cycle of the request. Writes, the warning and the redirect strobe take effect at the next rising clock edge. The status register and the exception-status register are driven out continuously for the rest of the core.

Top module: `spr_gate`

Address map, fixed by this block: version 0x000, unit-present 0x001, CPU-config 0x002, next-PC 0x010, status 0x011, previous-PC 0x012, FP control/status 0x014, exception PC 0x020, exception status 0x030, MAC low 0x040, MAC high 0x041, tick mode 0x050. The shadow window starts at `SHADOW_BASE` and holds `SHADOW_DEPTH` entries.

## Requirements
- R1: After a synchronous reset, `sr_o` equals 1 << `FO_BIT` and `esr_o` is 0. `warn` and `redir_vld` are 0, and `rd_data` is 0 while no read is requested.
- R2: When `priv_sm` and `priv_sumra` are both 0, a read returns 0 and a write changes no state. The access raises `warn` in the next cycle. If either bit is 1, the access is allowed.
- R3: Any address at or above `NUM_REGS` is invalid. A read of such an address returns 0 and a write to it is dropped, and both raise `warn` in the next cycle.
- R4: A privileged read of version, unit-present, CPU-config, status, previous-PC, FP control/status, exception PC, MAC low, MAC high or a shadow-window entry returns the value in the same cycle, with no warning.
- R5: A privileged read of any other in-range address returns 0 and raises `warn`. This covers next-PC, exception status, tick mode and unmapped holes.
- R6: A privileged write to FP control/status, exception PC, exception status, MAC low, MAC high or a shadow-window entry stores the data. The new value can be read from the next cycle on, and for exception status it also appears on `esr_o`.
- R7: A privileged write to the status register stores the data with bit `FO_BIT` forced to 1, and the result appears on `sr_o` in the next cycle.
- R8: A privileged write to next-PC stores nothing. In the next cycle it raises `redir_vld` for one cycle, with `redir_pc` equal to the write data, and it does not raise `warn`.
- R9: A privileged write to tick mode changes no state. It raises `warn` only when the data is nonzero.
- R10: A privileged write to any other in-range address, whether a read-only register or a hole, is dropped and raises `warn`.
- R11: With no request, `rd_data` is 0 and `warn` is 0 in the next cycle. If a read and a write arrive together, the read returns the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_req | input | 1 | Read request |
| wr_req | input | 1 | Write request |
| addr | input | ADDR_W | Register address |
| wdata | input | DATA_W | Write data |
| priv_sm | input | 1 | Supervisor-mode bit |
| priv_sumra | input | 1 | User read-permission bit |
| prev_pc | input | DATA_W | Previous-PC value for reads of that address |
| rd_data | output | DATA_W | Combinational read result |
| sr_o | output | DATA_W | Current status register |
| esr_o | output | DATA_W | Current exception status register |
| redir_vld | output | 1 | Redirect strobe; also clears delay-slot state |
| redir_pc | output | DATA_W | Redirect target |
| warn | output | 1 | Rejected or invalid access, registered |

## Verification
The bench builds the gate with `NUM_REGS` = 0x440, `SHADOW_BASE` = 0x400 and `SHADOW_DEPTH` = 64. With these values the shadow window ends exactly at the limit, so 0x43F is the last valid entry and 0x440 is the first invalid address, and every shadow entry can be filled and checked in a short run. The full 16-bit address width is kept, so random addresses far above the limit and in the holes below the window are exercised as well as the named registers.

// File: rtl/spr_gate_pkg.sv
package spr_gate_pkg;

  localparam logic [31:0] A_VER   = 32'h000;
  localparam logic [31:0] A_UNIT  = 32'h001;
  localparam logic [31:0] A_CFG   = 32'h002;
  localparam logic [31:0] A_NPC   = 32'h010;
  localparam logic [31:0] A_SR    = 32'h011;
  localparam logic [31:0] A_PPC   = 32'h012;
  localparam logic [31:0] A_FPCSR = 32'h014;
  localparam logic [31:0] A_EPCR  = 32'h020;
  localparam logic [31:0] A_ESR   = 32'h030;
  localparam logic [31:0] A_MACLO = 32'h040;
  localparam logic [31:0] A_MACHI = 32'h041;
  localparam logic [31:0] A_TICK  = 32'h050;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_VER, SEL_UNIT, SEL_CFG, SEL_SR, SEL_PPC, SEL_FPCSR,
    SEL_EPCR, SEL_ESR, SEL_MACLO, SEL_MACHI, SEL_SHADOW, SEL_NPC, SEL_TICK
  } spr_sel_e;

  typedef struct packed {
    spr_sel_e sel;
    logic     in_range;
    logic     readable;
    logic     storable;
  } spr_dec_t;

  localparam int N_PLAIN = 5;

endpackage

// File: rtl/spr_gate_decode.sv
module spr_gate_decode
  import spr_gate_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int NUM_REGS     = 32'h600,
  parameter int SHADOW_BASE  = 32'h400,
  parameter int SHADOW_DEPTH = 512,
  parameter int IDX_W        = 9
) (
  input  logic [ADDR_W-1:0] addr,
  output spr_dec_t          dec,
  output logic [IDX_W-1:0]  idx
);

  logic [31:0] a32;
  logic [31:0] rel;
  logic        in_win;

  assign a32    = 32'(addr);
  assign rel    = a32 - 32'(SHADOW_BASE);
  assign in_win = (a32 >= 32'(SHADOW_BASE)) && (rel < 32'(SHADOW_DEPTH));
  assign idx    = rel[IDX_W-1:0];

  always_comb begin
    dec.in_range = a32 < 32'(NUM_REGS);
    if (in_win) dec.sel = SEL_SHADOW;
    else begin
      case (a32)
        A_VER:   dec.sel = SEL_VER;
        A_UNIT:  dec.sel = SEL_UNIT;
        A_CFG:   dec.sel = SEL_CFG;
        A_NPC:   dec.sel = SEL_NPC;
        A_SR:    dec.sel = SEL_SR;
        A_PPC:   dec.sel = SEL_PPC;
        A_FPCSR: dec.sel = SEL_FPCSR;
        A_EPCR:  dec.sel = SEL_EPCR;
        A_ESR:   dec.sel = SEL_ESR;
        A_MACLO: dec.sel = SEL_MACLO;
        A_MACHI: dec.sel = SEL_MACHI;
        A_TICK:  dec.sel = SEL_TICK;
        default: dec.sel = SEL_NONE;
      endcase
    end
    case (dec.sel)
      SEL_VER, SEL_UNIT, SEL_CFG, SEL_SR, SEL_PPC, SEL_FPCSR, SEL_EPCR,
      SEL_MACLO, SEL_MACHI, SEL_SHADOW: dec.readable = dec.in_range;
      default:                          dec.readable = 1'b0;
    endcase
    case (dec.sel)
      SEL_FPCSR, SEL_EPCR, SEL_ESR, SEL_MACLO, SEL_MACHI, SEL_SHADOW:
               dec.storable = dec.in_range;
      default: dec.storable = 1'b0;
    endcase
  end

endmodule

// File: rtl/spr_gate_store.sv
module spr_gate_store
  import spr_gate_pkg::*;
#(
  parameter int DATA_W       = 32,
  parameter int SHADOW_DEPTH = 512,
  parameter int IDX_W        = 9,
  parameter int FO_BIT       = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              plain_we,
  input  logic              sr_we,
  input  spr_sel_e          sel,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_val,
  output logic [DATA_W-1:0] sr_o,
  output logic [DATA_W-1:0] esr_o
);

  localparam logic [DATA_W-1:0] FO_MASK = DATA_W'(1) << FO_BIT;
  localparam spr_sel_e PLAIN_SEL [N_PLAIN] =
    '{SEL_FPCSR, SEL_EPCR, SEL_ESR, SEL_MACLO, SEL_MACHI};
  localparam int ESR_SLOT = 2;

  logic [DATA_W-1:0] plain_q [N_PLAIN];
  logic [DATA_W-1:0] sr_q;
  logic [DATA_W-1:0] shadow_mem [SHADOW_DEPTH];

  // Shadow window: no reset, single write port, so it maps onto RAM.
  always_ff @(posedge clk) begin
    if (plain_we && sel == SEL_SHADOW) shadow_mem[idx] <= wdata;
  end

  for (genvar g = 0; g < N_PLAIN; g++) begin : g_plain
    always_ff @(posedge clk) begin
      if (rst)                                 plain_q[g] <= '0;
      else if (plain_we && sel == PLAIN_SEL[g]) plain_q[g] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        sr_q <= FO_MASK;
    else if (sr_we) sr_q <= wdata | FO_MASK;
  end

  always_comb begin
    rd_val = '0;
    if (sel == SEL_SR)     rd_val = sr_q;
    if (sel == SEL_SHADOW) rd_val = shadow_mem[idx];
    for (int i = 0; i < N_PLAIN; i++)
      if (sel == PLAIN_SEL[i]) rd_val = plain_q[i];
  end

  assign sr_o  = sr_q;
  assign esr_o = plain_q[ESR_SLOT];

endmodule

// File: rtl/spr_gate.sv
module spr_gate
  import spr_gate_pkg::*;
#(
  parameter int              ADDR_W       = 16,
  parameter int              DATA_W       = 32,
  parameter int              NUM_REGS     = 32'h600,
  parameter int              SHADOW_BASE  = 32'h400,
  parameter int              SHADOW_DEPTH = 512,
  parameter int              FO_BIT       = 15,
  parameter logic [DATA_W-1:0] VERSION_VAL = 32'h0001_0000,
  parameter logic [DATA_W-1:0] UNIT_VAL    = 32'h0000_0001,
  parameter logic [DATA_W-1:0] CFG_VAL     = 32'h0000_0020
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_req,
  input  logic              wr_req,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              priv_sm,
  input  logic              priv_sumra,
  input  logic [DATA_W-1:0] prev_pc,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] sr_o,
  output logic [DATA_W-1:0] esr_o,
  output logic              redir_vld,
  output logic [DATA_W-1:0] redir_pc,
  output logic              warn
);

  localparam int IDX_W = (SHADOW_DEPTH > 1) ? $clog2(SHADOW_DEPTH) : 1;

  spr_dec_t          dec;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] store_val;
  logic [DATA_W-1:0] mux_val;
  logic              priv, wr_go;
  logic              plain_we, sr_we, npc_hit, tick_hit;
  logic              rd_fault, wr_fault;
  logic              warn_q, redir_vld_q;
  logic [DATA_W-1:0] redir_pc_q;

  spr_gate_decode #(
    .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .SHADOW_BASE(SHADOW_BASE),
    .SHADOW_DEPTH(SHADOW_DEPTH), .IDX_W(IDX_W)
  ) u_dec (
    .addr(addr), .dec(dec), .idx(idx)
  );

  assign priv     = priv_sm | priv_sumra;
  assign wr_go    = wr_req & priv & dec.in_range;
  assign plain_we = wr_go & dec.storable;
  assign sr_we    = wr_go & (dec.sel == SEL_SR);
  assign npc_hit  = wr_go & (dec.sel == SEL_NPC);
  assign tick_hit = wr_go & (dec.sel == SEL_TICK);

  spr_gate_store #(
    .DATA_W(DATA_W), .SHADOW_DEPTH(SHADOW_DEPTH), .IDX_W(IDX_W), .FO_BIT(FO_BIT)
  ) u_store (
    .clk(clk), .rst(rst), .plain_we(plain_we), .sr_we(sr_we),
    .sel(dec.sel), .idx(idx), .wdata(wdata),
    .rd_val(store_val), .sr_o(sr_o), .esr_o(esr_o)
  );

  always_comb begin
    case (dec.sel)
      SEL_VER:  mux_val = VERSION_VAL;
      SEL_UNIT: mux_val = UNIT_VAL;
      SEL_CFG:  mux_val = CFG_VAL;
      SEL_PPC:  mux_val = prev_pc;
      default:  mux_val = store_val;
    endcase
  end

  assign rd_data  = (rd_req && priv && dec.readable) ? mux_val : '0;
  assign rd_fault = rd_req & ~(priv & dec.readable);
  assign wr_fault = (wr_req & ~(plain_we | sr_we | npc_hit | tick_hit))
                  | (tick_hit & (wdata != '0));

  always_ff @(posedge clk) begin
    if (rst) begin
      warn_q      <= 1'b0;
      redir_vld_q <= 1'b0;
      redir_pc_q  <= '0;
    end else begin
      warn_q      <= rd_fault | wr_fault;
      redir_vld_q <= npc_hit;
      if (npc_hit) redir_pc_q <= wdata;
    end
  end

  assign warn      = warn_q;
  assign redir_vld = redir_vld_q;
  assign redir_pc  = redir_pc_q;

endmodule

// File: rtl/spr_gate_chk.sv
module spr_gate_chk
  import spr_gate_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 32'h600,
  parameter int FO_BIT   = 15
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_req,
  input logic              wr_req,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic              priv_sm,
  input logic              priv_sumra,
  input logic [DATA_W-1:0] rd_data,
  input logic [DATA_W-1:0] sr_o,
  input logic              redir_vld,
  input logic [DATA_W-1:0] redir_pc,
  input logic              warn
);

  // R2
  unpriv_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !priv_sm && !priv_sumra) |-> rd_data == '0);

  // R2
  unpriv_warn_chk: assert property (@(posedge clk) disable iff (rst)
    ((rd_req || wr_req) && !priv_sm && !priv_sumra) |=> warn);

  // R3
  out_of_range_chk: assert property (@(posedge clk) disable iff (rst)
    ((rd_req || wr_req) && 32'(addr) >= 32'(NUM_REGS)) |=> warn);

  // R7
  sr_fixed_one_chk: assert property (@(posedge clk) disable iff (rst)
    sr_o[FO_BIT] == 1'b1);

  // R8
  redirect_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_req && !rd_req && (priv_sm || priv_sumra) && 32'(addr) == A_NPC
     && A_NPC < 32'(NUM_REGS)) |=> (redir_vld && !warn && redir_pc == $past(wdata)));

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!rd_req && !wr_req) |=> !warn);

  // R11
  idle_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_req |-> rd_data == '0);

endmodule

bind spr_gate spr_gate_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .FO_BIT(FO_BIT)
) u_chk (
  .clk(clk), .rst(rst), .rd_req(rd_req), .wr_req(wr_req), .addr(addr),
  .wdata(wdata), .priv_sm(priv_sm), .priv_sumra(priv_sumra),
  .rd_data(rd_data), .sr_o(sr_o), .redir_vld(redir_vld),
  .redir_pc(redir_pc), .warn(warn)
);

// File: tb/tb_spr_gate.sv
module tb_spr_gate;

  localparam int AW    = 16;
  localparam int DW    = 32;
  localparam int NREG  = 32'h440;
  localparam int SBASE = 32'h400;
  localparam int SDEP  = 64;
  localparam int FOB   = 15;
  localparam logic [31:0] VERV  = 32'h1234_0001;
  localparam logic [31:0] UNITV = 32'h0000_00A5;
  localparam logic [31:0] CFGV  = 32'h0000_0020;
  localparam logic [31:0] FOM   = 32'h1 << FOB;

  localparam logic [31:0] T_VER = 32'h000, T_UNIT = 32'h001, T_CFG = 32'h002;
  localparam logic [31:0] T_NPC = 32'h010, T_SR = 32'h011, T_PPC = 32'h012;
  localparam logic [31:0] T_FPC = 32'h014, T_EPC = 32'h020, T_ESR = 32'h030;
  localparam logic [31:0] T_MLO = 32'h040, T_MHI = 32'h041, T_TICK = 32'h050;

  logic          clk = 1'b0;
  logic          rst;
  logic          rd_req, wr_req, priv_sm, priv_sumra;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata, prev_pc;
  logic [DW-1:0] rd_data, sr_o, esr_o, redir_pc;
  logic          redir_vld, warn;

  always #4 clk = ~clk;

  spr_gate #(
    .ADDR_W(AW), .DATA_W(DW), .NUM_REGS(NREG), .SHADOW_BASE(SBASE),
    .SHADOW_DEPTH(SDEP), .FO_BIT(FOB),
    .VERSION_VAL(VERV), .UNIT_VAL(UNITV), .CFG_VAL(CFGV)
  ) dut (
    .clk(clk), .rst(rst), .rd_req(rd_req), .wr_req(wr_req), .addr(addr),
    .wdata(wdata), .priv_sm(priv_sm), .priv_sumra(priv_sumra),
    .prev_pc(prev_pc), .rd_data(rd_data), .sr_o(sr_o), .esr_o(esr_o),
    .redir_vld(redir_vld), .redir_pc(redir_pc), .warn(warn)
  );

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  logic [31:0] m_sr, m_fpc, m_epc, m_esr, m_mlo, m_mhi, m_redir_pc;
  logic [31:0] m_shadow [SDEP];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit in_win(input logic [31:0] a);
    return a >= SBASE && a < SBASE + SDEP;
  endfunction

  function automatic bit readable(input logic [31:0] a);
    if (a >= NREG) return 0;
    if (in_win(a)) return 1;
    return a == T_VER || a == T_UNIT || a == T_CFG || a == T_SR || a == T_PPC ||
           a == T_FPC || a == T_EPC || a == T_MLO || a == T_MHI;
  endfunction

  function automatic logic [31:0] model_read(input logic [31:0] a, input logic [31:0] ppc);
    if (in_win(a)) return m_shadow[a - SBASE];
    case (a)
      T_VER: return VERV;   T_UNIT: return UNITV; T_CFG: return CFGV;
      T_SR:  return m_sr;   T_PPC:  return ppc;   T_FPC: return m_fpc;
      T_EPC: return m_epc;  T_MLO:  return m_mlo; T_MHI: return m_mhi;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string rd_tag(input logic [31:0] a, input bit pv);
    if (!pv) return "R2";
    if (a >= NREG) return "R3";
    return readable(a) ? "R4" : "R5";
  endfunction

  // One access: inputs set at a falling edge, read checked 1 ns later,
  // registered outputs and state checked 2 ns after the next rising edge.
  task automatic op(input bit rd, input bit wr, input logic [31:0] a,
                    input logic [31:0] d, input bit sm, input bit su);
    bit          pv;
    bit          e_warn, e_redir;
    logic [31:0] e_rd;
    string       wtag, rtag;
    pv = sm | su;
    rd_req = rd; wr_req = wr; addr = a[AW-1:0]; wdata = d;
    priv_sm = sm; priv_sumra = su; prev_pc = $urandom;
    #1;
    rtag = rd ? rd_tag(a, pv) : "R11";
    e_rd = (rd && pv && readable(a)) ? model_read(a, prev_pc) : 32'h0;
    chk({rtag, " rd_data"}, rd_data, e_rd);
    e_warn  = rd && !(pv && readable(a));
    e_redir = 0;
    wtag = "R11";
    if (wr) begin
      if (!pv) begin e_warn = 1; wtag = "R2"; end
      else if (a >= NREG) begin e_warn = 1; wtag = "R3"; end
      else if (in_win(a)) begin m_shadow[a - SBASE] = d; wtag = "R6"; end
      else begin
        case (a)
          T_FPC:  begin m_fpc = d; wtag = "R6"; end
          T_EPC:  begin m_epc = d; wtag = "R6"; end
          T_ESR:  begin m_esr = d; wtag = "R6"; end
          T_MLO:  begin m_mlo = d; wtag = "R6"; end
          T_MHI:  begin m_mhi = d; wtag = "R6"; end
          T_SR:   begin m_sr = d | FOM; wtag = "R7"; end
          T_NPC:  begin e_redir = 1; m_redir_pc = d; wtag = "R8"; end
          T_TICK: begin if (d != 0) e_warn = 1; wtag = "R9"; end
          default: begin e_warn = 1; wtag = "R10"; end
        endcase
      end
    end else if (rd) wtag = rtag;
    @(posedge clk); #2;
    chk({wtag, " warn"}, {31'h0, warn}, {31'h0, e_warn});
    chk({wtag, " redir_vld"}, {31'h0, redir_vld}, {31'h0, e_redir});
    if (e_redir) chk("R8 redir_pc", redir_pc, m_redir_pc);
    chk({wtag, " sr_o"}, sr_o, m_sr);
    chk({wtag, " esr_o"}, esr_o, m_esr);
    rd_req = 0; wr_req = 0;
    @(negedge clk);
  endtask

  function automatic logic [31:0] pick_addr();
    int unsigned k = $urandom % 8;
    logic [31:0] named [12] = '{T_VER, T_UNIT, T_CFG, T_NPC, T_SR, T_PPC,
                                T_FPC, T_EPC, T_ESR, T_MLO, T_MHI, T_TICK};
    case (k)
      0, 1, 2: return named[$urandom % 12];
      3, 4:    return SBASE + ($urandom % SDEP);
      5:       return NREG + ($urandom % (32'h10000 - NREG));
      6:       return $urandom % 32'h60;
      default: return $urandom % NREG;
    endcase
  endfunction

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240));
    rst = 1; rd_req = 0; wr_req = 0; addr = '0; wdata = '0;
    priv_sm = 0; priv_sumra = 0; prev_pc = '0;
    m_sr = FOM; m_fpc = 0; m_epc = 0; m_esr = 0; m_mlo = 0; m_mhi = 0; m_redir_pc = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    // R1 reset state
    chk("R1 sr_o", sr_o, FOM);
    chk("R1 esr_o", esr_o, 32'h0);
    chk("R1 warn", {31'h0, warn}, 32'h0);
    chk("R1 redir_vld", {31'h0, redir_vld}, 32'h0);
    chk("R1 rd_data", rd_data, 32'h0);
    // R6 fill the whole shadow window, then read it back
    for (int i = 0; i < SDEP; i++) op(0, 1, SBASE + i, $urandom, 1, 0);
    for (int i = 0; i < SDEP; i++) op(1, 0, SBASE + i, 0, 0, 1);
    op(0, 1, T_ESR, 32'hCAFE_0001, 1, 0);        // R6 visible on esr_o
    op(1, 0, T_ESR, 0, 1, 0);                    // R5 not readable
    op(0, 1, T_SR, 32'h0, 1, 0);                 // R7 forced bit
    op(1, 0, T_SR, 0, 1, 0);
    op(0, 1, T_NPC, 32'h0000_2F00, 1, 0);        // R8
    op(1, 0, T_NPC, 0, 1, 0);                    // R5
    op(0, 1, T_TICK, 32'h0, 1, 0);               // R9 silent
    op(0, 1, T_TICK, 32'h1, 1, 0);               // R9 warn
    op(0, 1, T_VER, 32'hFFFF_FFFF, 1, 0);        // R10
    op(1, 0, T_VER, 0, 1, 0);                    // R4
    op(0, 1, T_FPC, 32'h55, 0, 0);               // R2 dropped
    op(1, 0, T_FPC, 0, 0, 1);                    // R2 sumra alone allows
    op(1, 0, T_PPC, 0, 0, 0);                    // R2 read zero
    op(1, 0, SBASE + SDEP - 1, 0, 1, 0);         // R4 last entry
    op(1, 0, NREG, 0, 1, 0);                     // R3 first invalid
    op(0, 1, NREG, 32'h9, 1, 0);                 // R3 write dropped
    op(1, 1, T_MLO, 32'h7777_0000, 1, 1);        // R11 read sees old value
    op(1, 0, T_MLO, 0, 1, 0);
    op(0, 0, T_SR, 0, 1, 0);                     // R11 idle
    for (int n = 0; n < 3000; n++) begin
      int unsigned kind = $urandom % 4;
      logic [31:0] a = pick_addr();
      logic [31:0] d = ($urandom % 4 == 0) ? 32'h0 : $urandom;
      int unsigned pr = $urandom % 4;
      op(kind == 1 || kind == 3, kind == 2 || kind == 3, a, d,
         pr[0] | (pr == 0 ? 1'b0 : pr[1]), pr[1]);
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule